// File: doc/BRIEF.md
# Latched Trigger Capture with Interrupt Request

The block watches ten external trigger lines: eight TTL-level lines and two ECL-level lines, all arriving as asynchronous levels. Each line first passes through a synchronizer. A rising edge on the synchronized line sets a sticky capture bit, but only when the enable bit for that line is on. A capture bit then stays set until software clears it. Software can poll the capture bits, or it can use a single interrupt request output. That output is high whenever any capture bit is set and the global interrupt enable input is high.

Access is through a small register bus with separate read and write strobes. One offset is split by direction. A write there loads the per-line enable mask. A read there returns the capture bits. A second offset is write-only: each one written to it clears the matching capture bit. Bit positions are the same for the mask, the capture word and the clear word. Bits 7..0 belong to TTL lines 7..0, and bits 9..8 belong to ECL lines 1..0. The upper bits read as zero. Read data is registered and is returned with a one-cycle valid strobe.

Top module: `trig_capture`

## Requirements
- R1: A write to offset 0x2E loads the enable mask from data bits 9..0. A read from offset 0x2E returns the capture word, not the mask, in bits 9..0, with bits 15..10 zero. The read data and the valid strobe appear on the cycle after the read strobe. A read from any other offset returns zero.
- R2: A rising edge on a trigger line whose enable bit is zero sets no capture bit.
- R3: A capture bit that has been set stays set after its trigger line returns low, until it is cleared.
- R4: A write to offset 0x30 clears every capture bit whose data bit is one. Capture bits whose data bit is zero are left unchanged.
- R5: The two ECL lines set capture bits 8 and 9 under the same enable rule as the TTL lines. Writes to offset 0x2E never change the capture bits.
- R6: The interrupt request is registered. One cycle after the capture word is non-zero while the interrupt enable is high, it is high. One cycle after the interrupt enable is low or the capture word is zero, it is low.
- R7: Capture is edge-triggered. A line held high after its bit has been cleared does not set the bit again until the line falls and rises once more.
- R8: A read of the capture word has no side effect. Two reads in a row return the same value.
- R9: When a new rising edge and a clear of the same bit land in the same cycle, the bit stays set.
- R10: Writes to offsets other than 0x2E and 0x30 change neither the mask nor the capture bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_ttl | input | 8 | Asynchronous TTL trigger lines |
| trig_ecl | input | 2 | Asynchronous ECL trigger lines |
| irq_enable | input | 1 | Global interrupt enable |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds a result |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that the bus strobes are clean single-cycle pulses that are never both high in the same cycle. The bench drives all inputs on the falling edge and issues one access at a time with idle cycles in between, so these assumptions hold. Trigger lines are held at each level for several cycles, longer than the synchronizer depth. The one exception is the same-cycle set-and-clear case. There the bench counts the synchronizer stages exactly, so that the clear write lands in the cycle where the edge is detected.

// File: rtl/trig_capture_pkg.sv
package trig_capture_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_MASK  = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_OTHER = 2'd3
  } acc_kind_e;

  function automatic acc_kind_e decode_offset(
    input logic [15:0] addr,
    input logic [15:0] mask_offs,
    input logic [15:0] clear_offs
  );
    if (addr == mask_offs)       return ACC_MASK;
    else if (addr == clear_offs) return ACC_CLEAR;
    else                         return ACC_OTHER;
  endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] line_in,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;

  // R7: an edge is a single-cycle event
  a_r7_single_cycle_rise: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/trig_bus_port.sv
module trig_bus_port
  import trig_capture_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int N_SRC      = 10,
  parameter int MASK_OFFS  = 'h2E,
  parameter int CLEAR_OFFS = 'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_SRC-1:0]  src_word,
  output logic              mask_we,
  output logic [N_SRC-1:0]  mask_wdata,
  output logic [N_SRC-1:0]  clr_vec,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  localparam int PAD_W = DATA_W - N_SRC;

  acc_kind_e kind;

  always_comb begin
    kind = decode_offset(16'(bus_addr), 16'(MASK_OFFS), 16'(CLEAR_OFFS));
  end

  assign mask_we    = bus_wr && (kind == ACC_MASK);
  assign mask_wdata = bus_wdata[N_SRC-1:0];
  assign clr_vec    = (bus_wr && (kind == ACC_CLEAR)) ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (kind == ACC_MASK) bus_rdata <= {{PAD_W{1'b0}}, src_word};
        else                  bus_rdata <= '0;
      end
    end
  end

  // R1: every read strobe yields exactly one valid strobe a cycle later
  a_r1_read_valid: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  // R1: unused high bits of read data stay zero
  a_r1_pad_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> (bus_rdata[DATA_W-1:N_SRC] == '0));

endmodule

// File: rtl/trig_source_bank.sv
module trig_source_bank #(
  parameter int N_SRC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] rise,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic [N_SRC-1:0] clr_vec,
  input  logic             irq_enable,
  output logic [N_SRC-1:0] src_word,
  output logic             irq
);

  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] src_q;
  logic [N_SRC-1:0] set_vec;

  assign set_vec = rise & mask_q;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= (src_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_enable && (src_q != '0);
  end

  assign src_word = src_q;

  // R2: a bit becomes set only where the enable mask was on
  a_r2_masked_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(mask_q)) == '0));
  // R3: set bits survive unless a clear names them
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(src_q) & ~$past(clr_vec) & ~src_q) == '0));
  // R4: a cleared bit without a fresh edge reads zero next cycle
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(clr_vec) & ~$past(rise) & src_q) == '0));
  // R9: a fresh enabled edge wins over a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rise) & $past(mask_q) & ~src_q) == '0));
  // R6: interrupt request follows the enable and the capture word
  a_r6_irq_off: assert property (@(posedge clk) disable iff (rst)
    (!irq_enable || (src_q == '0)) |=> !irq);
  a_r6_irq_on: assert property (@(posedge clk) disable iff (rst)
    (irq_enable && (src_q != '0)) |=> irq);

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int N_TTL       = 8,
  parameter int N_ECL       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int MASK_OFFS   = 'h2E,
  parameter int CLEAR_OFFS  = 'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TTL-1:0]  trig_ttl,
  input  logic [N_ECL-1:0]  trig_ecl,
  input  logic              irq_enable,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);

  localparam int N_SRC = N_TTL + N_ECL;

  logic [N_SRC-1:0] lines;
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] src_word;
  logic [N_SRC-1:0] mask_wdata;
  logic [N_SRC-1:0] clr_vec;
  logic             mask_we;

  assign lines = {trig_ecl, trig_ttl};

  trig_sync_edge #(
    .WIDTH  (N_SRC),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (lines),
    .rise    (rise)
  );

  trig_bus_port #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .N_SRC      (N_SRC),
    .MASK_OFFS  (MASK_OFFS),
    .CLEAR_OFFS (CLEAR_OFFS)
  ) i_bus (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .src_word   (src_word),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_vec    (clr_vec),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  trig_source_bank #(
    .N_SRC (N_SRC)
  ) i_bank (
    .clk        (clk),
    .rst        (rst),
    .rise       (rise),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .clr_vec    (clr_vec),
    .irq_enable (irq_enable),
    .src_word   (src_word),
    .irq        (irq)
  );

  // R10: the mask only loads from its own offset
  a_r10_mask_offset_only: assert property (@(posedge clk) disable iff (rst)
    mask_we |-> (bus_wr && (bus_addr == ADDR_W'(MASK_OFFS))));

endmodule

// File: tb/test_trig_capture.sv
module test_trig_capture;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  trig_ttl = '0;
  logic [1:0]  trig_ecl = '0;
  logic        irq_enable = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  trig_capture i_trig_capture (
    .clk(clk), .rst(rst), .trig_ttl(trig_ttl), .trig_ecl(trig_ecl),
    .irq_enable(irq_enable), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read results as they come out
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected read valid", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input int exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    idle(1);
  endtask

  task automatic pulse_ttl(input int b);
    @(negedge clk); trig_ttl[b] = 1'b1;
    idle(5);
    trig_ttl[b] = 1'b0;
    idle(5);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // reset state
    check("R6 irq low after reset", int'(irq), 0);
    bus_read(6'h2E, 0, "R1 capture word zero after reset");

    // R2: edge with mask off sets nothing
    pulse_ttl(3);
    bus_read(6'h2E, 0, "R2 masked-off edge ignored");

    // R1/R5: mask write does not show through the read side nor set bits
    bus_write(6'h2E, 16'h0108);
    bus_read(6'h2E, 0, "R5 mask write leaves capture word");
    bus_read(6'h10, 0, "R1 other offset reads zero");

    // R3: sticky after line falls
    pulse_ttl(3);
    bus_read(6'h2E, 16'h0008, "R3 bit3 held after line low");

    // R5: ECL line 0 -> bit 8, ECL line 1 masked off
    @(negedge clk); trig_ecl = 2'b11; idle(6); trig_ecl = 2'b00; idle(5);
    bus_read(6'h2E, 16'h0108, "R5 ECL bit8 set, bit9 masked");

    // R8: repeated read
    bus_read(6'h2E, 16'h0108, "R8 second read unchanged");

    // R6: interrupt gating
    check("R6 irq low with enable off", int'(irq), 0);
    @(negedge clk); irq_enable = 1'b1; idle(2);
    check("R6 irq high with enable on", int'(irq), 1);

    // R10: write to unrelated offset
    bus_write(6'h12, 16'hFFFF);
    bus_read(6'h2E, 16'h0108, "R10 stray write no clear");
    pulse_ttl(0);
    bus_read(6'h2E, 16'h0108, "R10 stray write no mask change");

    // R4: clear only bit 3
    bus_write(6'h30, 16'h0008);
    bus_read(6'h2E, 16'h0100, "R4 selective clear");

    // R7: line held high, cleared, no re-capture
    bus_write(6'h2E, 16'h0001);
    @(negedge clk); trig_ttl[0] = 1'b1; idle(5);
    bus_read(6'h2E, 16'h0101, "R7 held line captured once");
    bus_write(6'h30, 16'h0001);
    idle(5);
    bus_read(6'h2E, 16'h0100, "R7 held line no recapture");
    trig_ttl[0] = 1'b0; idle(5);

    // R9: edge detected in the same cycle as a clear of that bit
    pulse_ttl(0);
    bus_read(6'h2E, 16'h0101, "R9 bit0 set before race");
    @(negedge clk); trig_ttl[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h30; bus_wdata = 16'h0101;
    @(negedge clk);
    bus_wr = 1'b0;
    idle(2);
    bus_read(6'h2E, 16'h0001, "R9 set wins over clear, bit8 cleared");
    trig_ttl[0] = 1'b0; idle(4);

    // R4/R6: clear all, irq drops
    bus_write(6'h30, 16'h03FF);
    idle(2);
    bus_read(6'h2E, 0, "R4 clear all");
    check("R6 irq low with empty capture word", int'(irq), 0);

    idle(4);
    check("R1 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule